// File: doc/BRIEF.md
# Simple-Mode Parallel I/O Port Controller

This block is an I/O-mapped parallel port peripheral for an 8-bit, PC-style bus with a 10-bit I/O address. It claims eight consecutive locations. The upper seven address bits are compared with a switch input, so the base can be set in steps of 8 up to 0x3F8. The default switch setting of 7'h44 gives a base of 0x220. Behind the window are three 8-bit ports, A, B and C. Port C is split into a lower and an upper 4-bit half. That gives four sections, and each one has its own direction bit.

Software sets the directions with a write-only control word. A section set as output drives its pins from a held register, and a read of that section returns the held value. A section set as input does not drive its pins, and a read returns the live pin value during the read strobe. An interrupt request is formed from port C bits 3 and 7. Each of these bits is taken from the pin or from the held register, depending on its half's direction, and the result is gated by an enable input.

Bus accesses use active-low read and write strobes. The block has separate data-in and data-out buses and a data-out enable. A write takes effect on each rising clock edge while the write strobe is low at a claimed address.

Top module: `pio_mode0_ctrl`

## Requirements
- R1: An access is claimed only when addr_i[9:3] equals base_sw_i. At any other address, writes change nothing and reads do not drive the bus.
- R2: Offsets are decoded from addr_i[2:0] as follows.
  - 0 is port A.
  - 1 is port B.
  - 2 is port C, with data bits 3:0 for the lower half and 7:4 for the upper half.
  - 3 is the control word, which is write-only.
  - Offsets 4 to 7 have no effect.
- R3: The control word sets each section's direction, where 1 means input and 0 means output.
  - Bit 4 controls port A.
  - Bit 1 controls port B.
  - Bit 0 controls the lower half of port C.
  - Bit 3 controls the upper half of port C.
- R4: A control word is accepted only when bit 7 is 1 and bits 6 and 5 are 0. Any other control word leaves directions, held values and pins unchanged.
- R5: An accepted control word sets every held output register to zero in the same edge that loads the new directions.
- R6: A section set as output drives its pins with its held value, with the matching output enable high. A read of that section returns the held value.
- R7: A section set as input keeps its output enable low, including after it is written. A read of that section returns the live pin value.
- R8: After reset, every section is an input, no output enable is high, every held value is zero and irq_o is low.
- R9: Each clock, irq_o is registered as irq_en_i AND (bit 3 OR bit 7 of port C). Each of these bits comes from the pin when its half is an input and from the held register when its half is an output.
- R10: data_oe_o is high only while rd_ni is low at a claimed address with offset 0, 1 or 2.
- R11: A write to port A, port B or port C loads the held register of each addressed section, whatever its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 10 | I/O address |
| base_sw_i | input | 7 | Base select, compared with addr_i[9:3] |
| data_i | input | 8 | Write data |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data drive enable |
| irq_en_i | input | 1 | Interrupt enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A pins out |
| pa_oe_o | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B pins out |
| pb_oe_o | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C pins out |
| pc_oe_o | output | 2 | Port C drive enables: bit 0 for the lower half, bit 1 for the upper half |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that rd_ni and wr_ni are never low in the same cycle. They also assume that base_sw_i stays fixed while the block runs, because the decode checks compare the live address with the live switch value. The stimulus meets both assumptions. Each access drops exactly one strobe for one clock. Pins, switches and the interrupt enable change only on falling clock edges, and the switch value is never changed after reset.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned NSECT  = 4;
  localparam int unsigned SECT_A = 0;
  localparam int unsigned SECT_B = 1;
  localparam int unsigned SECT_CL = 2;
  localparam int unsigned SECT_CH = 3;

  typedef enum logic [2:0] {
    OFF_PA   = 3'd0,
    OFF_PB   = 3'd1,
    OFF_PC   = 3'd2,
    OFF_CTRL = 3'd3
  } off_e;

  // control-word bit that sets each section's direction
  function automatic int unsigned cw_bit(input int unsigned sect);
    case (sect)
      SECT_A:  cw_bit = 4;
      SECT_B:  cw_bit = 1;
      SECT_CL: cw_bit = 0;
      default: cw_bit = 3;
    endcase
  endfunction

  function automatic logic cw_valid(input logic [7:0] cw);
    cw_valid = cw[7] & ~cw[6] & ~cw[5];
  endfunction
endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
  parameter int unsigned AW   = 10,
  parameter int unsigned OFFW = 3,
  localparam int unsigned BW  = AW - OFFW
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   base_sw_i,
  output logic            hit_o,
  output logic [OFFW-1:0] off_o
);
  assign hit_o = (addr_i[AW-1:OFFW] == base_sw_i);
  assign off_o = addr_i[OFFW-1:0];
endmodule

// File: rtl/pio_dir_reg.sv
module pio_dir_reg
  import pio_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             clr_o,
  output logic [NSECT-1:0] dir_in_o
);
  logic accept;
  logic [NSECT-1:0] dir_d;

  assign accept = wr_i & cw_valid(wdata_i[7:0]);
  assign clr_o  = accept;

  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    assign dir_d[g] = wdata_i[cw_bit(g)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_in_o <= '1;
    else if (accept) dir_in_o <= dir_d;
  end
endmodule

// File: rtl/pio_sect.sv
module pio_sect #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_in_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic         oe_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_q <= '0;
    else if (clr_i) held_q <= '0;
    else if (wr_i)  held_q <= wdata_i;
  end

  assign pin_o = held_q;
  assign oe_o  = ~dir_in_i;
  assign rd_o  = dir_in_i ? pin_i : held_q;
endmodule

// File: rtl/pio_mode0_ctrl.sv
module pio_mode0_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned AW     = 10,
  parameter int unsigned OFFW   = 3,
  parameter int unsigned PORT_W = 8,
  localparam int unsigned BW    = AW - OFFW,
  localparam int unsigned HW    = PORT_W / 2,
  localparam int unsigned TOTW  = 3 * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [BW-1:0]     base_sw_i,
  input  logic [PORT_W-1:0] data_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic [PORT_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              irq_en_i,
  input  logic [PORT_W-1:0] pa_i,
  output logic [PORT_W-1:0] pa_o,
  output logic              pa_oe_o,
  input  logic [PORT_W-1:0] pb_i,
  output logic [PORT_W-1:0] pb_o,
  output logic              pb_oe_o,
  input  logic [PORT_W-1:0] pc_i,
  output logic [PORT_W-1:0] pc_o,
  output logic [1:0]        pc_oe_o,
  output logic              irq_o
);
  logic            hit;
  logic [OFFW-1:0] off;
  logic            wr_hit, ctrl_wr, clr;
  logic [NSECT-1:0] dir_in, oe, sect_wr;
  logic [TOTW-1:0] pin_in, pin_out, rd_val;
  logic [PORT_W-1:0] rd_a, rd_b, rd_c;
  logic            irq_src;

  pio_addr_dec #(.AW(AW), .OFFW(OFFW)) u_dec (
    .addr_i   (addr_i),
    .base_sw_i(base_sw_i),
    .hit_o    (hit),
    .off_o    (off)
  );

  assign wr_hit  = ~wr_ni & hit;
  assign ctrl_wr = wr_hit & (off == OFFW'(OFF_CTRL));

  pio_dir_reg #(.DW(PORT_W)) u_dir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctrl_wr),
    .wdata_i (data_i),
    .clr_o   (clr),
    .dir_in_o(dir_in)
  );

  assign sect_wr[SECT_A]  = wr_hit & (off == OFFW'(OFF_PA));
  assign sect_wr[SECT_B]  = wr_hit & (off == OFFW'(OFF_PB));
  assign sect_wr[SECT_CL] = wr_hit & (off == OFFW'(OFF_PC));
  assign sect_wr[SECT_CH] = wr_hit & (off == OFFW'(OFF_PC));

  assign pin_in = {pc_i, pb_i, pa_i};

  for (genvar g = 0; g < NSECT; g++) begin : g_sect
    localparam int unsigned SW = (g < 2) ? PORT_W : HW;
    localparam int unsigned LO = (g < 2) ? g * PORT_W : 2 * PORT_W + (g - 2) * HW;
    localparam int unsigned DL = (g == SECT_CH) ? HW : 0;
    pio_sect #(.W(SW)) u_sect (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .wr_i    (sect_wr[g]),
      .wdata_i (data_i[DL +: SW]),
      .dir_in_i(dir_in[g]),
      .pin_i   (pin_in[LO +: SW]),
      .pin_o   (pin_out[LO +: SW]),
      .oe_o    (oe[g]),
      .rd_o    (rd_val[LO +: SW])
    );
  end

  assign pa_o    = pin_out[0 +: PORT_W];
  assign pb_o    = pin_out[PORT_W +: PORT_W];
  assign pc_o    = pin_out[2*PORT_W +: PORT_W];
  assign pa_oe_o = oe[SECT_A];
  assign pb_oe_o = oe[SECT_B];
  assign pc_oe_o = {oe[SECT_CH], oe[SECT_CL]};

  assign rd_a = rd_val[0 +: PORT_W];
  assign rd_b = rd_val[PORT_W +: PORT_W];
  assign rd_c = rd_val[2*PORT_W +: PORT_W];

  always_comb begin
    data_o    = '0;
    data_oe_o = 1'b0;
    if (~rd_ni && hit) begin
      case (off)
        OFFW'(OFF_PA): begin data_o = rd_a; data_oe_o = 1'b1; end
        OFFW'(OFF_PB): begin data_o = rd_b; data_oe_o = 1'b1; end
        OFFW'(OFF_PC): begin data_o = rd_c; data_oe_o = 1'b1; end
        default: ;
      endcase
    end
  end

  // bit 3 of each port C half
  assign irq_src = rd_c[3] | rd_c[HW+3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_en_i & irq_src;
  end
endmodule

// File: rtl/pio_mode0_ctrl_chk.sv
module pio_mode0_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] addr_i,
  input logic [6:0] base_sw_i,
  input logic [7:0] data_i,
  input logic       rd_ni,
  input logic       wr_ni,
  input logic [7:0] data_o,
  input logic       data_oe_o,
  input logic       irq_en_i,
  input logic [7:0] pa_i,
  input logic [7:0] pa_o,
  input logic       pa_oe_o,
  input logic [7:0] pb_i,
  input logic [7:0] pb_o,
  input logic       pb_oe_o,
  input logic [7:0] pc_i,
  input logic [7:0] pc_o,
  input logic [1:0] pc_oe_o,
  input logic       irq_o
);
  logic claim, cw_ok, c3, c7;
  assign claim = (addr_i[9:3] == base_sw_i);
  assign cw_ok = (data_i[7:5] == 3'b100);
  assign c3 = pc_oe_o[0] ? pc_o[3] : pc_i[3];
  assign c7 = pc_oe_o[1] ? pc_o[7] : pc_i[7];

  assert_rd_drive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!rd_ni && claim && addr_i[2:0] < 3'd3));

  assert_ctrl_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && claim && addr_i[2:0] == 3'd3 && cw_ok) |=>
      (pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00));

  assert_ctrl_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && claim && addr_i[2:0] == 3'd3 && cw_ok) |=>
      (pa_oe_o == !$past(data_i[4]) && pb_oe_o == !$past(data_i[1]) &&
       pc_oe_o[0] == !$past(data_i[0]) && pc_oe_o[1] == !$past(data_i[3])));

  assert_ctrl_ignore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && claim && addr_i[2:0] == 3'd3 && !cw_ok) |=>
      $stable({pa_oe_o, pb_oe_o, pc_oe_o, pa_o, pb_o, pc_o}));

  assert_out_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && claim && addr_i[2:0] == 3'd0 && pa_oe_o) |=>
      (pa_oe_o && pa_o == $past(data_i)));

  assert_in_nodrive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && claim && addr_i[2:0] == 3'd1 && !pb_oe_o) |=> !pb_oe_o);

  assert_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(irq_en_i && (c3 || c7))));
endmodule

bind pio_mode0_ctrl pio_mode0_ctrl_chk u_chk (.*);

// File: tb/tb_pio_mode0_ctrl.sv
module tb_pio_mode0_ctrl;
  localparam logic [6:0] BASE_SW = 7'h44;
  localparam logic [9:0] BASE    = 10'h220;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic [6:0] base_sw = BASE_SW;
  logic [7:0] din = '0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] dout;
  logic doe;
  logic irq_en = 1'b0;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;
  logic [7:0] pa_o, pb_o, pc_o;
  logic pa_oe, pb_oe, irq;
  logic [1:0] pc_oe;

  int total = 0, bad = 0;
  bit done = 0;

  // model: dir bit 1 = input; sections a,b,cl,ch
  logic [3:0] m_dir = 4'hF;
  logic [7:0] m_a = 0, m_b = 0, m_c = 0;

  always #4 clk = ~clk;

  pio_mode0_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .base_sw_i(base_sw),
    .data_i(din), .rd_ni(rd_n), .wr_ni(wr_n), .data_o(dout), .data_oe_o(doe),
    .irq_en_i(irq_en), .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe), .pc_i(pc_i), .pc_o(pc_o),
    .pc_oe_o(pc_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] off);
    case (off)
      3'd0: return m_dir[0] ? pa_i : m_a;
      3'd1: return m_dir[1] ? pb_i : m_b;
      default: return {m_dir[3] ? pc_i[7:4] : m_c[7:4], m_dir[2] ? pc_i[3:0] : m_c[3:0]};
    endcase
  endfunction

  function automatic logic exp_irq();
    logic [7:0] c;
    c = exp_rd(3'd2);
    return irq_en & (c[3] | c[7]);
  endfunction

  task automatic model_wr(input logic [9:0] a, input logic [7:0] d);
    if (a[9:3] != BASE_SW) return;
    case (a[2:0])
      3'd0: m_a = d;
      3'd1: m_b = d;
      3'd2: m_c = d;
      3'd3: if (d[7:5] == 3'b100) begin
        m_a = 0; m_b = 0; m_c = 0;
        m_dir = {d[3], d[0], d[1], d[4]};
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    model_wr(a, d);
  endtask

  task automatic rd_chk(input logic [9:0] a, input string req);
    @(negedge clk);
    addr = a; rd_n = 1'b0;
    #2;
    if (a[9:3] == BASE_SW && a[2:0] < 3) begin
      chk({req, " data_oe"}, doe, 1);
      chk({req, " data"}, dout, exp_rd(a[2:0]));
    end else begin
      chk({req, " no drive"}, doe, 0);
    end
    rd_n = 1'b1;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " oe_a"}, pa_oe, !m_dir[0]);
    chk({req, " oe_b"}, pb_oe, !m_dir[1]);
    chk({req, " oe_c"}, pc_oe, {!m_dir[3], !m_dir[2]});
    if (!m_dir[0]) chk({req, " pa_o"}, pa_o, m_a);
    if (!m_dir[1]) chk({req, " pb_o"}, pb_o, m_b);
    if (!m_dir[2]) chk({req, " pc_o lo"}, pc_o[3:0], m_c[3:0]);
    if (!m_dir[3]) chk({req, " pc_o hi"}, pc_o[7:4], m_c[7:4]);
  endtask

  task automatic irq_chk(input string req);
    @(negedge clk);
    chk(req, irq, exp_irq());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 oe", {pa_oe, pb_oe, pc_oe}, 0);
    chk("R8 irq", irq, 0);
    chk("R8 data_oe", doe, 0);
    rst_n = 1'b1;
    pa_i = 8'hA5; pb_i = 8'h3C; pc_i = 8'h00;
    rd_chk(BASE + 0, "R8 R7 read A live");

    // R3 R5 R6 all outputs
    wr(BASE + 3, 8'h80);
    chk_pins("R3 cw80");
    wr(BASE + 0, 8'h12); wr(BASE + 1, 8'h34); wr(BASE + 2, 8'h56);
    chk_pins("R6 R2 out");
    rd_chk(BASE + 0, "R6 read A");
    rd_chk(BASE + 1, "R6 read B");
    rd_chk(BASE + 2, "R6 read C");

    // R4 invalid control words
    wr(BASE + 3, 8'h1B);
    chk_pins("R4 bit7 clear");
    wr(BASE + 3, 8'hA0);
    chk_pins("R4 bit5 set");
    chk("R4 held kept", pb_o, 8'h34);

    // R5 valid control clears held
    wr(BASE + 3, 8'h80);
    chk("R5 clear a", pa_o, 0);
    chk("R5 clear c", pc_o, 0);

    // 0x92: A,B inputs, C output
    wr(BASE + 3, 8'h92);
    chk_pins("R3 cw92");
    wr(BASE + 0, 8'h77);
    chk("R7 write input A no drive", pa_oe, 0);
    rd_chk(BASE + 0, "R7 read A live");

    // R11 held register of input section loaded and visible by readback after direction change is lost (clear), so check via output C
    wr(BASE + 2, 8'h9E);
    rd_chk(BASE + 2, "R11 R2 C split");

    // R1 foreign address
    wr(10'h228, 8'h00);
    chk("R1 foreign write", pc_o, 8'h9E);
    rd_chk(10'h228, "R1 foreign read");
    // R2 / R10 offsets 3..7
    rd_chk(BASE + 3, "R10 ctrl read");
    rd_chk(BASE + 5, "R10 offset5 read");
    wr(BASE + 6, 8'h80);
    chk_pins("R2 offset6 write");

    // R9 irq
    irq_en = 1'b1;
    wr(BASE + 2, 8'h08);
    irq_chk("R9 out bit3");
    wr(BASE + 2, 8'h00);
    irq_chk("R9 out clear");
    wr(BASE + 3, 8'h9B);
    @(negedge clk); pc_i = 8'h80;
    irq_chk("R9 in bit7");
    @(negedge clk); irq_en = 1'b0;
    irq_chk("R9 gated");

    // mixed random
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [9:0] a;
      op = $urandom_range(0, 4);
      @(negedge clk);
      pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
      irq_en = 1'($urandom);
      a = ($urandom_range(0, 7) == 0) ? 10'($urandom) : BASE + 10'($urandom_range(0, 7));
      case (op)
        0: wr(BASE + 3, 8'h80 | 8'($urandom_range(0, 31)));
        1, 2: wr(a, 8'($urandom));
        default: rd_chk(a, "R7 R6 R1 rand read");
      endcase
      chk_pins("R3 R6 rand pins");
      irq_chk("R9 rand irq");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule